// File: doc/BRIEF.md
# Dual-Mode Bit-Serial Montgomery Multiplier

This block is a fixed-width radix-2 multiplier with two modes. In Montgomery mode it takes operands A and B and an odd modulus M, all `WIDTH` bits wide, and returns A·B·2^-WIDTH mod M, fully reduced. In plain mode it skips reduction and returns the full 2·`WIDTH`-bit product A·B, split into a high half and a low half. Both modes run on the same adder and accumulator. They scan the bits of A one per clock, least significant bit first, so a word-level scheduler outside the block can use plain mode as the product step of a multi-word modular multiplication.

An operation begins on a clock edge where `start` is high and `busy` is low. On that edge the block captures the mode, the operands and the modulus, and it holds them internally until the operation ends. `busy` stays high while the operation runs, and `start` has no effect during that time. `done` is high for a single cycle, and the results are valid in that cycle. There is no back-pressure on the output. The result pins keep their value until the next accepted start, so a consumer that cannot take the result in the `done` cycle can read it later. A new start may be given in the same cycle that `done` is high.

Top module: `dual_mont_mul`

## Requirements
- R1: With `mode`=0 (Montgomery), B ≤ M and M odd, `res_lo` equals A·B·2^-WIDTH mod M and `res_hi` is zero when `done` is high.
- R2: With `mode`=1 (plain), {`res_hi`,`res_lo`} equals A·B when `done` is high, for any value on `modulus`, even ones included.
- R3: In plain mode, `done` rises in the cycle after the WIDTH-th clock edge that follows the accepting edge.
- R4: In Montgomery mode, one extra correction cycle subtracts M once if needed. `done` rises after WIDTH+1 edges, and `res_lo` is then below M.
- R5: A start is accepted only on an edge where `busy` is low. `busy` is high from the next cycle until the `done` cycle, and low in the `done` cycle.
- R6: A `start` pulse given while `busy` is high is ignored. It does not change the running operation's mode, operands or result.
- R7: `done` is high for exactly one cycle per operation, and `busy` is never high at the same time as `done`.
- R8: While the block is idle, `res_hi` and `res_lo` keep the last result until the next accepted start.
- R9: A start given in the cycle where `done` is high is accepted. That cycle's result is still seen correctly, and the new operation completes correctly.
- R10: After reset, `busy`, `done`, `res_hi` and `res_lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when `busy` is low |
| mode | input | 1 | 0 = Montgomery, 1 = plain product |
| op_a | input | WIDTH | Multiplier A, scanned bit-serially |
| op_b | input | WIDTH | Multiplicand B |
| modulus | input | WIDTH | Odd modulus M, ignored in plain mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| res_hi | output | WIDTH | High half of the product (zero in Montgomery mode) |
| res_lo | output | WIDTH | Low half of the product, or the Montgomery result |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle: `done` high, with `start` high in that cycle. The bench provokes this by raising `start` at the falling edge on which it sees `done`. It then checks that the finished result is correct in that cycle and that the new operation, with different operands and the other mode, returns its own correct result after its full latency. A second overlap is a start that arrives while an operation runs. This stimulus is held for several cycles with different operands and the opposite mode, and the result that follows is checked against the first request only.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
  typedef enum logic {
    MODE_MONT  = 1'b0,
    MODE_PLAIN = 1'b1
  } mmul_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ITER = 2'd1,
    PH_FIX  = 2'd2
  } mmul_phase_e;
endpackage

// File: rtl/mmul_ctrl.sv
module mmul_ctrl
  import mmul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  mmul_mode_e mode_q,
  output logic       busy,
  output logic       done,
  output logic       load_en,
  output logic       step_en,
  output logic       fix_en
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mmul_phase_e phase;
  logic [CW-1:0] cnt;

  assign busy    = (phase != PH_IDLE);
  assign load_en = start && (phase == PH_IDLE);
  assign step_en = (phase == PH_ITER);
  assign fix_en  = (phase == PH_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_ITER;
            cnt   <= '0;
          end
        end
        PH_ITER: begin
          cnt <= cnt + CW'(1);
          if (cnt == LAST) begin
            if (mode_q == MODE_PLAIN) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end else begin
              phase <= PH_FIX;
            end
          end
        end
        PH_FIX: begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R5
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R4
  fix_follows_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |-> $past(step_en));
endmodule

// File: rtl/mmul_step.sv
module mmul_step
  import mmul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH+1:0] acc,
  input  logic             a_bit,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] m,
  input  mmul_mode_e       mode,
  output logic [WIDTH+1:0] acc_nxt,
  output logic             lo_bit
);
  localparam int AW = WIDTH + 2;

  logic [AW-1:0] partial;
  logic [AW-1:0] reduced;
  logic          q;

  always_comb begin
    partial = acc + (a_bit ? {2'b00, b} : {AW{1'b0}});
    q       = (mode == MODE_MONT) && partial[0];
    reduced = partial + (q ? {2'b00, m} : {AW{1'b0}});
    acc_nxt = {1'b0, reduced[AW-1:1]};
    lo_bit  = reduced[0];
  end
endmodule

// File: rtl/mmul_regs.sv
module mmul_regs
  import mmul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             step_en,
  input  logic             fix_en,
  input  mmul_mode_e       mode_in,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] m_in,
  input  logic [WIDTH+1:0] acc_nxt,
  input  logic             lo_bit,
  input  logic             fix_take,
  input  logic [WIDTH-1:0] fix_val,
  output logic [WIDTH+1:0] acc_q,
  output logic [WIDTH-1:0] lo_q,
  output logic [WIDTH-1:0] a_q,
  output logic [WIDTH-1:0] b_q,
  output logic [WIDTH-1:0] m_q,
  output mmul_mode_e       mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lo_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      m_q    <= '0;
      mode_q <= MODE_MONT;
    end else if (load_en) begin
      acc_q  <= '0;
      lo_q   <= '0;
      a_q    <= a_in;
      b_q    <= b_in;
      m_q    <= m_in;
      mode_q <= mode_in;
    end else if (step_en) begin
      acc_q <= acc_nxt;
      lo_q  <= {lo_bit, lo_q[WIDTH-1:1]};
      a_q   <= {1'b0, a_q[WIDTH-1:1]};
    end else if (fix_en && fix_take) begin
      acc_q <= {2'b00, fix_val};
    end
  end

  // R6
  operands_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en || fix_en) |=> ($stable(b_q) && $stable(m_q) && $stable(mode_q)));
  // R2
  plain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PLAIN) |-> (acc_q[WIDTH+1:WIDTH] == 2'b00));
  // R1
  odd_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && mode_in == MODE_MONT) |-> m_in[0]);
  // R1
  mont_lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mode_q == MODE_MONT) |-> !lo_bit);
  // R4
  reduced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |=> (acc_q < {2'b00, m_q}));
endmodule

// File: rtl/mmul_fix.sv
module mmul_fix
  import mmul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH+1:0] acc_q,
  input  logic [WIDTH-1:0] lo_q,
  input  logic [WIDTH-1:0] m_q,
  input  mmul_mode_e       mode_q,
  output logic             fix_take,
  output logic [WIDTH-1:0] fix_val,
  output logic [WIDTH-1:0] res_hi,
  output logic [WIDTH-1:0] res_lo
);
  logic [WIDTH+1:0] m_ext;
  logic [WIDTH+1:0] diff;

  always_comb begin
    m_ext    = {2'b00, m_q};
    diff     = acc_q - m_ext;
    fix_take = (acc_q >= m_ext);
    fix_val  = diff[WIDTH-1:0];
    if (mode_q == MODE_PLAIN) begin
      res_hi = acc_q[WIDTH-1:0];
      res_lo = lo_q;
    end else begin
      res_hi = '0;
      res_lo = acc_q[WIDTH-1:0];
    end
  end
endmodule

// File: rtl/dual_mont_mul.sv
module dual_mont_mul
  import mmul_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] modulus,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] res_hi,
  output logic [WIDTH-1:0] res_lo
);
  logic             load_en, step_en, fix_en;
  logic [WIDTH+1:0] acc_q, acc_nxt;
  logic [WIDTH-1:0] lo_q, a_q, b_q, m_q, fix_val;
  logic             lo_bit, fix_take;
  mmul_mode_e       mode_q, mode_in;

  assign mode_in = mmul_mode_e'(mode);

  mmul_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_q(mode_q),
    .busy(busy), .done(done), .load_en(load_en), .step_en(step_en), .fix_en(fix_en)
  );

  mmul_step #(.WIDTH(WIDTH)) step_i (
    .acc(acc_q), .a_bit(a_q[0]), .b(b_q), .m(m_q), .mode(mode_q),
    .acc_nxt(acc_nxt), .lo_bit(lo_bit)
  );

  mmul_regs #(.WIDTH(WIDTH)) regs_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .step_en(step_en), .fix_en(fix_en),
    .mode_in(mode_in), .a_in(op_a), .b_in(op_b), .m_in(modulus),
    .acc_nxt(acc_nxt), .lo_bit(lo_bit), .fix_take(fix_take), .fix_val(fix_val),
    .acc_q(acc_q), .lo_q(lo_q), .a_q(a_q), .b_q(b_q), .m_q(m_q), .mode_q(mode_q)
  );

  mmul_fix #(.WIDTH(WIDTH)) fix_i (
    .acc_q(acc_q), .lo_q(lo_q), .m_q(m_q), .mode_q(mode_q),
    .fix_take(fix_take), .fix_val(fix_val), .res_hi(res_hi), .res_lo(res_lo)
  );

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !$past(busy)) |=> ($stable(res_hi) && $stable(res_lo)));
endmodule

// File: tb/dual_mont_mul_tb.sv
module dual_mont_mul_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, modulus = 16'd1;
  logic busy, done;
  logic [W-1:0] res_hi, res_lo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit m_busy = 0, m_done = 0, m_valid = 0, m_mode = 0;
  int m_cnt = 0;
  logic [2*W-1:0] m_exp = '0, m_held = '0;
  logic [W-1:0] m_mod = '0;

  always #5 clk = ~clk;

  dual_mont_mul #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_a(op_a), .op_b(op_b),
    .modulus(modulus), .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo)
  );

  function automatic logic [W-1:0] mont_ref(input logic [W-1:0] a, b, m);
    longint unsigned r, inv2, mm;
    mm   = longint'(m);
    inv2 = (mm + 1) / 2;
    r    = (longint'(a) * longint'(b)) % mm;
    for (int k = 0; k < W; k++) r = (r * inv2) % mm;
    return W'(r);
  endfunction

  function automatic logic [2*W-1:0] expect_of(input bit md, input logic [W-1:0] a, b, m);
    if (md) return (2*W)'(longint'(a) * longint'(b));
    return {{W{1'b0}}, mont_ref(a, b, m)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [2*W-1:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-level reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_valid = 1; m_held = '0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_held = m_exp; m_valid = 1;
        end
      end else if (start) begin
        m_busy = 1; m_mode = mode; m_mod = modulus; m_valid = 0;
        m_cnt  = mode ? W : W + 1;
        m_exp  = expect_of(mode, op_a, op_b, modulus);
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R5 busy", {31'd0, busy}, {31'd0, m_busy});
      chk(done == m_done, m_mode ? "R3 plain latency/R7 pulse" : "R4 mont latency/R7 pulse",
          {31'd0, done}, {31'd0, m_done});
      if (m_done) begin
        chk({res_hi, res_lo} == m_held, m_mode ? "R2 plain product" : "R1 mont result",
            {res_hi, res_lo}, m_held);
        if (!m_mode)
          chk(res_lo < m_mod, "R4 reduced below M", {16'd0, res_lo}, {16'd0, m_mod});
      end else if (m_valid && !m_busy) begin
        chk({res_hi, res_lo} == m_held, "R8 idle hold", {res_hi, res_lo}, m_held);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R5 watchdog act=%0d exp=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input bit md, input logic [W-1:0] a, b, m);
    @(negedge clk);
    start = 1; mode = md; op_a = a; op_b = b; modulus = m;
    @(negedge clk);
    start = 0;
    while (m_busy) @(negedge clk);
  endtask

  task automatic rand_mont();
    logic [W-1:0] m, a, b;
    m = W'($urandom) | W'(1) | (W'(1) << (W - 1));
    a = W'($urandom);
    b = W'(longint'($urandom) % (longint'(m) + 1));
    run(0, a, b, m);
  endtask

  initial begin
    logic [2*W-1:0] exp1, exp2;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 0, "R10 reset busy", {31'd0, busy}, '0);
    chk(done == 0, "R10 reset done", {31'd0, done}, '0);
    chk({res_hi, res_lo} == '0, "R10 reset results", {res_hi, res_lo}, '0);
    rst_n = 1;
    @(negedge clk);

    // corner cases, plain (R2, R3); even modulus ignored
    run(1, 16'h0000, 16'h1234, 16'h0002);
    run(1, 16'hABCD, 16'h0000, 16'h0000);
    run(1, 16'hFFFF, 16'hFFFF, 16'h8000);
    run(1, 16'h8001, 16'h7FFF, 16'h1234);
    // corner cases, Montgomery (R1, R4)
    run(0, 16'h0000, 16'h0005, 16'h000B);
    run(0, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    run(0, 16'hFFFF, 16'h0000, 16'hFFFF);
    run(0, 16'h1357, 16'hFFFE, 16'hFFFF);
    run(0, 16'hFFFF, 16'h0001, 16'h0003);
    for (int i = 0; i < 20; i++) begin
      rand_mont();
      run(1, W'($urandom), W'($urandom), W'($urandom));
    end

    // R6: start held high during busy with other operands and mode
    exp1 = expect_of(0, 16'h4321, 16'h00FF, 16'h0101);
    @(negedge clk);
    start = 1; mode = 0; op_a = 16'h4321; op_b = 16'h00FF; modulus = 16'h0101;
    @(negedge clk);
    mode = 1; op_a = 16'hFFFF; op_b = 16'hEEEE; modulus = 16'h0003;
    repeat (3) @(negedge clk);
    start = 0;
    while (m_busy) @(negedge clk);
    chk({res_hi, res_lo} == exp1, "R6 start ignored while busy", {res_hi, res_lo}, exp1);

    // R9: start given in the done cycle
    exp1 = expect_of(1, 16'hC0DE, 16'hBEEF, 16'h0000);
    exp2 = expect_of(0, 16'h7777, 16'h1000, 16'h2001);
    @(negedge clk);
    start = 1; mode = 1; op_a = 16'hC0DE; op_b = 16'hBEEF; modulus = 16'h0000;
    @(negedge clk);
    start = 0;
    while (!m_done) @(negedge clk);
    chk({res_hi, res_lo} == exp1, "R9 result in overlap cycle", {res_hi, res_lo}, exp1);
    start = 1; mode = 0; op_a = 16'h7777; op_b = 16'h1000; modulus = 16'h2001;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R9 back-to-back accepted", {31'd0, busy}, 32'd1);
    while (m_busy) @(negedge clk);
    chk({res_hi, res_lo} == exp2, "R9 second result", {res_hi, res_lo}, exp2);
    repeat (4) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule